// File: doc/BRIEF.md
# Packed-BCD Decimal Adjust Unit

This unit repairs a byte that came out of a plain binary addition of two packed-BCD operands, so that the byte again holds two valid decimal digits. It takes the raw byte, the carry flag and the nibble (half) carry flag left by the addition. It returns the corrected byte and an updated carry flag, one clock edge after the inputs are presented.

The correction works one digit at a time, starting with the low digit. The low digit is corrected when it is out of decimal range or when the half carry is set. The high digit is corrected when it is out of range or when the carry is set, and that carry includes any carry produced by the low correction. A carry out of either correction sets the carry flag. The adjust never clears the carry flag, so a final carry of 1 means the decimal sum reached one hundred. This lets software chain byte-wide decimal additions. The half carry flag is passed through unchanged.

The digit count is a parameter, with a default of two digits (one byte). The top module registers the result with a synchronous active-low reset.

Top module: `bcd_adjust_unit`

## Requirements
- R1: While rst_n is low at a clock edge, acc_out, cy_out and ac_out are all 0 after that edge.
- R2: If bits [3:0] of acc_in exceed 9, or ac_in is 1, then 06h is added to the byte. Otherwise the low digit gets no correction, and bits [3:0] of the result equal those of acc_in.
- R3: When adding 06h in the low step carries out of bit 7, cy_out is 1.
- R4: After the low step, if the carry (cy_in or the carry from R3) is 1, or bits [7:4] of the intermediate byte exceed 9, then 60h is added. Otherwise nothing more is added.
- R5: When adding 60h carries out of bit 7, cy_out is 1.
- R6: cy_in = 1 always gives cy_out = 1. The adjust can set the carry but never clears it.
- R7: The result minus acc_in, taken modulo 256, is always one of 00h, 06h, 60h or 66h.
- R8: ac_out equals the ac_in presented at the previous clock edge. The adjust does not change it.
- R9: For two valid packed-BCD bytes X and Y, feed in their binary sum, the carry out of bit 7 and the carry out of bit 3. The result is then the packed-BCD form of (X+Y) mod 100, and cy_out = 1 exactly when X+Y is at least 100.
- R10: The result for inputs sampled at a clock edge appears right after that edge. Before that edge the outputs still hold the previous result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_in | input | 8 | Raw byte from the binary addition (4*DIGITS bits) |
| cy_in | input | 1 | Carry flag before the adjust |
| ac_in | input | 1 | Half carry flag (carry out of bit 3) before the adjust |
| acc_out | output | 8 | Corrected packed-BCD byte, registered |
| cy_out | output | 1 | Carry flag after the adjust, registered |
| ac_out | output | 1 | Half carry flag, passed through, registered |

## Verification
Every fault in the digit chain shows up at acc_out and cy_out one edge after the faulty input. A wrong low-step condition changes the low digit of acc_out by 6. A lost carry between the two stages shows up as a missing 60h correction for bytes from FAh upward. A carry that gets cleared shows up as cy_out = 0 with cy_in = 1.

The bench sweeps every byte with all four combinations of the two flags. It also runs all ten thousand pairs of two-digit decimal additions. Any such fault is therefore reported on the first vector that exposes it.

// File: rtl/bcd_adj_pkg.sv
// Package: constants shared by the decimal adjust stages.
// Assumes packed-BCD digits of four bits each.
package bcd_adj_pkg;
    localparam int unsigned NIB_W     = 4;
    localparam logic [3:0]  DIGIT_MAX = 4'd9;
    localparam logic [3:0]  DIGIT_FIX = 4'd6;
endpackage

// File: rtl/bcd_digit_fix.sv
// One digit correction stage.
// Adds 6 into digit POS of the whole word when that digit is above 9, or when
// the selected flag is set. For the lowest digit the flag is the half carry;
// for higher digits it is the running carry. A carry out of the word sets the
// running carry, which is never cleared.
// Assumes the lower digits have already been corrected by earlier stages.
module bcd_digit_fix
    import bcd_adj_pkg::*;
#(
    parameter int unsigned W      = 8,
    parameter int unsigned POS    = 0,
    parameter bit          USE_AC = 1'b1
) (
    input  logic [W-1:0] val_i,
    input  logic         cy_i,
    input  logic         hint_i,
    output logic [W-1:0] val_o,
    output logic         cy_o
);
    localparam int unsigned LSB = NIB_W * POS;

    logic [NIB_W-1:0] nib;
    logic             flag;
    logic             need;
    logic [W:0]       addend;
    logic [W:0]       sum;

    // Decide whether this digit needs the +6 correction.
    always_comb begin
        nib  = val_i[LSB +: NIB_W];
        flag = USE_AC ? hint_i : cy_i;
        need = (nib > DIGIT_MAX) || flag;
    end

    // Add the correction across the full width and collect the carry out.
    always_comb begin
        addend = need ? ((W+1)'(DIGIT_FIX) << LSB) : '0;
        sum    = {1'b0, val_i} + addend;
        val_o  = sum[W-1:0];
        cy_o   = cy_i | sum[W];
    end
endmodule

// File: rtl/bcd_adjust_core.sv
// Combinational chain of digit stages, from the lowest digit upward.
// Each stage sees the word and the carry left by the stage below it, so a
// carry produced by a lower correction forces the next digit's correction.
module bcd_adjust_core
    import bcd_adj_pkg::*;
#(
    parameter int unsigned DIGITS = 2,
    localparam int unsigned W     = NIB_W * DIGITS
) (
    input  logic [W-1:0] raw_i,
    input  logic         cy_i,
    input  logic         ac_i,
    output logic [W-1:0] fixed_o,
    output logic         cy_o
);
    logic [W-1:0] stage_val [0:DIGITS];
    logic         stage_cy  [0:DIGITS];

    // Feed the chain with the raw inputs.
    always_comb begin
        stage_val[0] = raw_i;
        stage_cy[0]  = cy_i;
    end

    for (genvar k = 0; k < DIGITS; k++) begin : g_digit
        bcd_digit_fix #(
            .W      (W),
            .POS    (k),
            .USE_AC (k == 0)
        ) u_fix (
            .val_i  (stage_val[k]),
            .cy_i   (stage_cy[k]),
            .hint_i (ac_i),
            .val_o  (stage_val[k+1]),
            .cy_o   (stage_cy[k+1])
        );
    end

    // Take the result from the top of the chain.
    always_comb begin
        fixed_o = stage_val[DIGITS];
        cy_o    = stage_cy[DIGITS];
    end
endmodule

// File: rtl/bcd_adjust_unit.sv
// Top of the decimal adjust unit.
// Registers the corrected word, the updated carry and the passed-through half
// carry on every rising edge. Reset is synchronous and active low.
// Assumes the inputs are the result of a binary addition of packed-BCD data.
module bcd_adjust_unit
    import bcd_adj_pkg::*;
#(
    parameter int unsigned DIGITS = 2,
    localparam int unsigned W     = NIB_W * DIGITS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] acc_in,
    input  logic         cy_in,
    input  logic         ac_in,
    output logic [W-1:0] acc_out,
    output logic         cy_out,
    output logic         ac_out
);
    logic [W-1:0] fixed_w;
    logic         cy_w;

    bcd_adjust_core #(.DIGITS(DIGITS)) u_core (
        .raw_i   (acc_in),
        .cy_i    (cy_in),
        .ac_i    (ac_in),
        .fixed_o (fixed_w),
        .cy_o    (cy_w)
    );

    // Capture the adjusted result, or clear it in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_out <= '0;
            cy_out  <= 1'b0;
            ac_out  <= 1'b0;
        end else begin
            acc_out <= fixed_w;
            cy_out  <= cy_w;
            ac_out  <= ac_in;
        end
    end

    // R6: a set carry going in always comes out set.
    p_sticky_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cy_in |=> cy_out);

    // R8: the half carry leaves the unit as it came in.
    p_ac_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ac_out == $past(ac_in)));

    // R2: the low digit of the correction is 6 exactly when its condition held.
    p_low_fix_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (W'(acc_out - $past(acc_in)) & W'(4'hF))
                 == (($past(acc_in[3:0]) > DIGIT_MAX || $past(ac_in)) ? W'(DIGIT_FIX) : W'(0)));

    // R5: a newly raised carry implies the high correction was applied.
    p_new_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cy_out && !$past(cy_in))
                  ? (W'(acc_out - $past(acc_in)) >> (W - NIB_W)) == W'(DIGIT_FIX)
                  : 1'b1));

    if (DIGITS == 2) begin : g_two_digit_chk
        // R7: only four correction values are possible on a byte.
        p_corr_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (W'(acc_out - $past(acc_in)) == W'(8'h00) ||
                      W'(acc_out - $past(acc_in)) == W'(8'h06) ||
                      W'(acc_out - $past(acc_in)) == W'(8'h60) ||
                      W'(acc_out - $past(acc_in)) == W'(8'h66)));
    end
endmodule

// File: tb/test_bcd_adjust_unit.sv
// Bench: full sweep of byte and flags, then every two-digit decimal addition.
module test_bcd_adjust_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 60000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] acc_in = 8'h00;
    logic       cy_in = 1'b0;
    logic       ac_in = 1'b0;
    logic [7:0] acc_out;
    logic       cy_out;
    logic       ac_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcd_adjust_unit #(.DIGITS(2)) i_bcd_adjust_unit (
        .clk(clk), .rst_n(rst_n), .acc_in(acc_in), .cy_in(cy_in), .ac_in(ac_in),
        .acc_out(acc_out), .cy_out(cy_out), .ac_out(ac_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected result worked out from the step rules.
    task automatic model(input int a, input bit c, input bit h, output int r, output bit rc,
                         output bit low_carry, output bit high_carry);
        r = a; rc = c; low_carry = 1'b0; high_carry = 1'b0;
        if ((r % 16) > 9 || h) begin
            r = r + 6;
            if (r > 255) begin rc = 1'b1; low_carry = 1'b1; r = r - 256; end
        end
        if (rc || (r / 16) > 9) begin
            r = r + 96;
            if (r > 255) begin rc = 1'b1; high_carry = 1'b1; r = r - 256; end
        end
    endtask

    function automatic int to_bcd(input int v);
        return ((v / 10) * 16) + (v % 10);
    endfunction

    // Present one vector, then check the registered result after the edge.
    task automatic apply(input int a, input bit c, input bit h);
        int r; bit rc; bit lc; bit hc; int delta;
        @(negedge clk);
        acc_in = 8'(a); cy_in = c; ac_in = h;
        @(negedge clk);
        model(a, c, h, r, rc, lc, hc);
        chk(acc_out == 8'(r), "R2 R4 adjusted byte", acc_out, r);
        chk(cy_out == rc, "R3 R5 carry", cy_out, rc);
        if (lc) chk(cy_out == 1'b1, "R3 low-step carry", cy_out, 1);
        if (hc) chk(cy_out == 1'b1, "R5 high-step carry", cy_out, 1);
        if (c)  chk(cy_out == 1'b1, "R6 carry kept", cy_out, 1);
        chk(ac_out == h, "R8 half carry", ac_out, h);
        delta = (int'(acc_out) - a + 256) % 256;
        chk(delta == 0 || delta == 6 || delta == 96 || delta == 102,
            "R7 correction set", delta, 102);
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        acc_in = 8'h99; cy_in = 1'b1; ac_in = 1'b1;
        repeat (3) @(negedge clk);
        chk(acc_out == 8'h00, "R1 reset byte", acc_out, 0);
        chk(cy_out == 1'b0, "R1 reset carry", cy_out, 0);
        chk(ac_out == 1'b0, "R1 reset half carry", ac_out, 0);
        rst_n = 1'b1;

        // R10: outputs hold until the edge, then carry the new result.
        @(negedge clk);
        acc_in = 8'h81; cy_in = 1'b0; ac_in = 1'b1;
        @(negedge clk);
        chk(acc_out == 8'h87, "R10 first result", acc_out, 8'h87);
        chk(cy_out == 1'b0, "R10 first carry", cy_out, 0);
        acc_in = 8'h9A; cy_in = 1'b0; ac_in = 1'b0;
        #1;
        chk(acc_out == 8'h87, "R10 held before edge", acc_out, 8'h87);
        @(negedge clk);
        chk(acc_out == 8'h00 && cy_out == 1'b1, "R10 after edge", acc_out, 0);

        // R2 R3 R4 R5 R6 R7 R8: every byte under every flag combination.
        for (int a = 0; a < 256; a++)
            for (int f = 0; f < 4; f++)
                apply(a, f[1], f[0]);

        // R3: low step alone overflows the byte.
        apply(8'hFB, 1'b0, 1'b0);
        chk(acc_out == 8'h61, "R3 FB wrap", acc_out, 8'h61);

        // R9: every pair of two-digit decimal operands.
        for (int x = 0; x < 100; x++) begin
            for (int y = 0; y < 100; y++) begin
                int bx; int by; int s;
                bx = to_bcd(x); by = to_bcd(y); s = bx + by;
                @(negedge clk);
                acc_in = 8'(s);
                cy_in  = (s > 255);
                ac_in  = ((bx % 16) + (by % 16)) > 15;
                @(negedge clk);
                chk(acc_out == 8'(to_bcd((x + y) % 100)), "R9 decimal sum",
                    acc_out, to_bcd((x + y) % 100));
                chk(cy_out == ((x + y) >= 100), "R9 hundreds carry", cy_out, (x + y) >= 100);
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule